// File: doc/BRIEF.md
# Discontinuous-PWM Full-Bridge Gate Generator

This block drives the four switches of a single-phase full bridge from one signed modulation command. A symmetric triangle carrier is made by an up-down counter. The command is split by sign. Its positive part sets the on-time of the first leg, and the positive part of its negation sets the on-time of the second leg. The leg that gets a zero compare value keeps its upper switch off and its lower switch on for the whole period. Only one leg switches at any time, which lowers switching loss and common-mode swing.

Each leg turns its raw compare result into a complementary pair of active-high gates through a dead-time state machine. When the counter passes through zero, the block raises a one-cycle trigger. This trigger starts the external current sample and also asks the controller for a new command. Because the sample falls at the carrier valley, it captures the period-average current for either sign of the command. The command is copied into shadow compare registers only in the trigger cycle. A value computed from the sample at instant k therefore governs the period k+1.

Carrier states: `CAR_IDLE` (held in reset), `CAR_UP` and `CAR_DOWN`. The transitions are: IDLE to UP on the first clock after reset; UP to DOWN when the count reaches PRD; DOWN to UP when the count reaches zero. Gate states per leg: `GT_OFF`, `GT_DEAD_TO_A`, `GT_A`, `GT_DEAD_TO_B` and `GT_B`. The transitions are: OFF to DEAD_TO_A or DEAD_TO_B at the first trigger, chosen by the raw compare; A to DEAD_TO_B when the raw compare drops; B to DEAD_TO_A when the raw compare rises; a dead state moves on to its target after DT clocks; a dead state reverses to the other dead state, with its timer restarted, if the raw compare flips during the wait.

Top module: `dpwm_hbridge`

## Requirements
- R1: The carrier has a period of 2*PRD clocks. `trig_o` is a one-cycle pulse once per period, in the cycle where the count is zero. The first pulse comes in the first clock after reset is released.
- R2: Compare value per leg = min(PRD, floor(m*PRD/32768)). Here m is the positive part of the command for leg 1, and the positive part of the negated command for leg 2. The command is a two's-complement 16-bit fraction. A leg's raw compare is high for 2*cmp clocks per period.
- R3: The leg whose compare value is zero holds its upper gate low and its lower gate high for every clock of the period.
- R4: Within a leg the two gates are never high together. After either gate falls, the other gate rises no earlier than DT clocks later. For 0<cmp<PRD the steady per-period on-time is max(0, 2*cmp-DT) for the upper gate and max(0, 2*(PRD-cmp)-DT) for the lower gate.
- R5: The command is captured only in the trigger cycle. A change at any other time has no effect on the gates until the cycle after the next trigger cycle.
- R6: All four gates are low while reset is asserted and until the first trigger. Both lower gates rise in the clock DT+2 after reset release, when the command is zero.
- R7: A command of -32768 saturates leg 2 to full scale, so its upper gate stays high for the whole period. A command of +32767 gives compare value PRD-1 on leg 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | CMD_W | Signed modulation command, fraction of full scale |
| trig_o | output | 1 | Carrier-zero pulse: starts the sample and requests an update |
| leg1_hi_o | output | 1 | Leg 1 upper gate, active high |
| leg1_lo_o | output | 1 | Leg 1 lower gate, active high |
| leg2_hi_o | output | 1 | Leg 2 upper gate, active high |
| leg2_lo_o | output | 1 | Leg 2 lower gate, active high |

## Verification
A small carrier of PRD=16 with DT=3 is swept over every compare value from zero to full scale for both signs of the command, plus a few off-grid values. These runs tell apart the sign split, the idle-leg clamp, the two saturation corners, and the dead-time trimming of short and long pulses. A mid-period command change is compared clock by clock against the pattern of the previous period. This shows whether the shadow load waits for the trigger. The trigger spacing and the reset-to-first-gate timing are counted from reset release.

// File: rtl/dpwm_pkg.sv
`timescale 1ns/1ps
package dpwm_pkg;
    localparam int NUM_LEGS = 2;

    typedef enum logic [1:0] {
        CAR_IDLE,
        CAR_UP,
        CAR_DOWN
    } car_state_t;

    typedef enum logic [2:0] {
        GT_OFF,
        GT_DEAD_TO_A,
        GT_A,
        GT_DEAD_TO_B,
        GT_B
    } gate_state_t;
endpackage

// File: rtl/dpwm_carrier.sv
`timescale 1ns/1ps
module dpwm_carrier
    import dpwm_pkg::*;
#(
    parameter int PRD   = 2500,
    parameter int CNT_W = $clog2(PRD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o,
    output logic             down_o,
    output logic             zero_o
);
    car_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CAR_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state: count up to PRD, then back down to zero
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            CAR_IDLE: begin
                st_d  = CAR_UP;
                cnt_d = '0;
            end
            CAR_UP: begin
                if (cnt_q == CNT_W'(PRD - 1)) begin
                    cnt_d = CNT_W'(PRD);
                    st_d  = CAR_DOWN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            CAR_DOWN: begin
                if (cnt_q == CNT_W'(1)) begin
                    cnt_d = '0;
                    st_d  = CAR_UP;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                st_d  = CAR_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        cnt_o  = cnt_q;
        down_o = (st_q == CAR_DOWN);
        zero_o = (st_q == CAR_UP) && (cnt_q == '0);
    end
endmodule

// File: rtl/dpwm_shadow.sv
`timescale 1ns/1ps
module dpwm_shadow
    import dpwm_pkg::*;
#(
    parameter int PRD   = 2500,
    parameter int CMD_W = 16,
    parameter int CNT_W = $clog2(PRD + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic signed [CMD_W-1:0]           cmd_i,
    input  logic                              load_i,
    output logic [NUM_LEGS-1:0][CNT_W-1:0]    cmp_o
);
    localparam int PW = CMD_W + 1 + CNT_W;

    logic signed [CMD_W:0]              cmd_ext;
    logic [NUM_LEGS-1:0][CNT_W-1:0]     cmp_d;
    logic [NUM_LEGS-1:0][CNT_W-1:0]     cmp_q;

    assign cmd_ext = {cmd_i[CMD_W-1], cmd_i};

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        logic signed [CMD_W:0] sgn;
        logic [CMD_W:0]        mag;
        logic [PW-1:0]         prod;
        logic [PW-1:0]         scl;

        if (g == 0) begin : g_pos
            assign sgn = cmd_ext;
        end else begin : g_neg
            assign sgn = -cmd_ext;
        end

        // positive half only; the other sign clamps this leg
        assign mag  = sgn[CMD_W] ? '0 : $unsigned(sgn);
        assign prod = PW'(mag) * PW'(PRD);
        assign scl  = prod >> (CMD_W - 1);
        assign cmp_d[g] = (scl > PW'(PRD)) ? CNT_W'(PRD) : scl[CNT_W-1:0];
    end

    // shadow load, only at the carrier valley
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (load_i) begin
            cmp_q <= cmp_d;
        end
    end

    assign cmp_o = cmp_q;
endmodule

// File: rtl/dpwm_leg.sv
`timescale 1ns/1ps
module dpwm_leg
    import dpwm_pkg::*;
#(
    parameter int DT    = 125,
    parameter int CNT_W = 12,
    parameter int DT_W  = $clog2(DT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             down_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             zero_i,
    output logic             gate_hi_o,
    output logic             gate_lo_o
);
    gate_state_t     st_q, st_d;
    logic [DT_W-1:0] tmr_q, tmr_d;
    logic            raw;

    // symmetric compare: cnt < cmp rising, cnt <= cmp falling
    assign raw = down_i ? (cnt_i <= cmp_i) : (cnt_i < cmp_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= GT_OFF;
            tmr_q <= '0;
        end else begin
            st_q  <= st_d;
            tmr_q <= tmr_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        tmr_d = tmr_q;
        unique case (st_q)
            GT_OFF: begin
                if (zero_i) begin
                    st_d  = raw ? GT_DEAD_TO_A : GT_DEAD_TO_B;
                    tmr_d = '0;
                end
            end
            GT_DEAD_TO_A: begin
                if (!raw) begin
                    st_d  = GT_DEAD_TO_B;
                    tmr_d = '0;
                end else if (tmr_q == DT_W'(DT - 1)) begin
                    st_d  = GT_A;
                end else begin
                    tmr_d = tmr_q + 1'b1;
                end
            end
            GT_A: begin
                if (!raw) begin
                    st_d  = GT_DEAD_TO_B;
                    tmr_d = '0;
                end
            end
            GT_DEAD_TO_B: begin
                if (raw) begin
                    st_d  = GT_DEAD_TO_A;
                    tmr_d = '0;
                end else if (tmr_q == DT_W'(DT - 1)) begin
                    st_d  = GT_B;
                end else begin
                    tmr_d = tmr_q + 1'b1;
                end
            end
            GT_B: begin
                if (raw) begin
                    st_d  = GT_DEAD_TO_A;
                    tmr_d = '0;
                end
            end
            default: begin
                st_d  = GT_OFF;
                tmr_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        gate_hi_o = (st_q == GT_A);
        gate_lo_o = (st_q == GT_B);
    end
endmodule

// File: rtl/dpwm_hbridge.sv
`timescale 1ns/1ps
module dpwm_hbridge
    import dpwm_pkg::*;
#(
    parameter int PRD   = 2500,
    parameter int DT    = 125,
    parameter int CMD_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [CMD_W-1:0] cmd_i,
    output logic                    trig_o,
    output logic                    leg1_hi_o,
    output logic                    leg1_lo_o,
    output logic                    leg2_hi_o,
    output logic                    leg2_lo_o
);
    localparam int CNT_W = $clog2(PRD + 1);
    localparam int DT_W  = $clog2(DT + 1);

    logic [CNT_W-1:0]                car_cnt;
    logic                            car_down;
    logic                            car_zero;
    logic [NUM_LEGS-1:0][CNT_W-1:0]  cmp_q;
    logic [NUM_LEGS-1:0]             leg_hi;
    logic [NUM_LEGS-1:0]             leg_lo;

    dpwm_carrier #(.PRD(PRD), .CNT_W(CNT_W)) u_carrier (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (car_cnt),
        .down_o (car_down),
        .zero_o (car_zero)
    );

    dpwm_shadow #(.PRD(PRD), .CMD_W(CMD_W), .CNT_W(CNT_W)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd_i),
        .load_i (car_zero),
        .cmp_o  (cmp_q)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        dpwm_leg #(.DT(DT), .CNT_W(CNT_W), .DT_W(DT_W)) u_leg (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_i     (car_cnt),
            .down_i    (car_down),
            .cmp_i     (cmp_q[g]),
            .zero_i    (car_zero),
            .gate_hi_o (leg_hi[g]),
            .gate_lo_o (leg_lo[g])
        );
    end

    assign trig_o    = car_zero;
    assign leg1_hi_o = leg_hi[0];
    assign leg1_lo_o = leg_lo[0];
    assign leg2_hi_o = leg_hi[1];
    assign leg2_lo_o = leg_lo[1];
endmodule

// File: rtl/dpwm_hbridge_chk.sv
`timescale 1ns/1ps
module dpwm_hbridge_chk
    import dpwm_pkg::*;
#(
    parameter int PRD   = 2500,
    parameter int DT    = 125,
    parameter int CNT_W = $clog2(PRD + 1)
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           trig,
    input logic [NUM_LEGS-1:0]            hi,
    input logic [NUM_LEGS-1:0]            lo,
    input logic [NUM_LEGS-1:0][CNT_W-1:0] cmp
);
    localparam int DT_W = $clog2(DT + 1);
    localparam int TC_W = $clog2(2 * PRD + 1);

    logic [TC_W-1:0] tc;
    logic            seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc   <= '0;
            seen <= 1'b0;
        end else begin
            if (trig) begin
                tc   <= '0;
                seen <= 1'b1;
            end else if (tc != TC_W'(2 * PRD)) begin
                tc <= tc + 1'b1;
            end
        end
    end

    // R1: spacing of the valley pulse
    p_trig_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && seen) |-> (tc == TC_W'(2 * PRD - 1)));
    p_trig_due_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && tc == TC_W'(2 * PRD - 1)) |-> trig);

    // R6: quiet until first valley
    p_quiet_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> (hi == '0 && lo == '0));
    always @(posedge clk) begin
        if (!rst_n) begin
            a_reset_quiet_r6: assert (hi == '0 && lo == '0);
        end
    end

    // R5: compare registers move only after a valley
    p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(trig) |-> $stable(cmp));

    // R3: at most one leg modulating
    p_one_leg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp[0] != '0 && cmp[1] != '0));

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        logic [DT_W-1:0] since_hi, since_lo;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                since_hi <= DT_W'(DT);
                since_lo <= DT_W'(DT);
            end else begin
                since_hi <= hi[g] ? '0 : ((since_hi == DT_W'(DT)) ? since_hi : since_hi + 1'b1);
                since_lo <= lo[g] ? '0 : ((since_lo == DT_W'(DT)) ? since_lo : since_lo + 1'b1);
            end
        end

        // R2: compare within full scale
        p_cmp_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
            cmp[g] <= CNT_W'(PRD));

        // R4: no overlap and dead-time gaps
        p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(hi[g] && lo[g]));
        p_gap_to_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lo[g]) |-> (since_hi >= DT_W'(DT)));
        p_gap_to_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hi[g]) |-> (since_lo >= DT_W'(DT)));
    end
endmodule

bind dpwm_hbridge dpwm_hbridge_chk #(.PRD(PRD), .DT(DT), .CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (trig_o),
    .hi    (leg_hi),
    .lo    (leg_lo),
    .cmp   (cmp_q)
);

// File: tb/dpwm_hbridge_tb.sv
`timescale 1ns/1ps
module dpwm_hbridge_tb;
    localparam int PRD = 16;
    localparam int DT  = 3;
    localparam int PER = 2 * PRD;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [15:0] cmd = '0;
    logic               trig, l1h, l1l, l2h, l2l;
    int                 checks = 0;
    int                 errors = 0;
    bit                 done = 1'b0;
    logic               pat [0:PER-1];

    always #5 clk = ~clk;

    dpwm_hbridge #(.PRD(PRD), .DT(DT), .CMD_W(16)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd),
        .trig_o    (trig),
        .leg1_hi_o (l1h),
        .leg1_lo_o (l1l),
        .leg2_hi_o (l2h),
        .leg2_lo_o (l2l)
    );

    function automatic int scale(int v);
        int m;
        int r;
        m = (v > 0) ? v : 0;
        r = (m * PRD) / 32768;
        if (r > PRD) r = PRD;
        return r;
    endfunction

    function automatic int exp_hi(int c);
        if (c == 0) return 0;
        if (c == PRD) return PER;
        return (2 * c > DT) ? 2 * c - DT : 0;
    endfunction

    function automatic int exp_lo(int c);
        if (c == 0) return PER;
        if (c == PRD) return 0;
        return (2 * (PRD - c) > DT) ? 2 * (PRD - c) - DT : 0;
    endfunction

    function automatic string tag_of(int c);
        if (c == 0) return "R3";
        if (c == PRD) return "R7";
        return "R4";
    endfunction

    task automatic check(string tag, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic run_cmd(int v);
        int n1h, n1l, n2h, n2l, ovl, c1, c2;
        @(negedge clk);
        cmd = 16'(v);
        repeat (4 * PER) @(negedge clk);
        n1h = 0; n1l = 0; n2h = 0; n2l = 0; ovl = 0;
        for (int i = 0; i < PER; i++) begin
            n1h += int'(l1h);
            n1l += int'(l1l);
            n2h += int'(l2h);
            n2l += int'(l2l);
            if ((l1h && l1l) || (l2h && l2l)) ovl++;
            @(negedge clk);
        end
        c1 = scale(v);
        c2 = scale(-v);
        check(tag_of(c1), $sformatf("leg1 upper on-time cmd=%0d (R2)", v), n1h, exp_hi(c1));
        check(tag_of(c1), $sformatf("leg1 lower on-time cmd=%0d (R2)", v), n1l, exp_lo(c1));
        check(tag_of(c2), $sformatf("leg2 upper on-time cmd=%0d (R2)", v), n2h, exp_hi(c2));
        check(tag_of(c2), $sformatf("leg2 lower on-time cmd=%0d (R2)", v), n2l, exp_lo(c2));
        check("R4", $sformatf("overlap cycles cmd=%0d", v), ovl, 0);
    endtask

    initial begin
        int last;
        int cyc;
        int seen_cnt;
        int wide;

        // R6: quiet in reset
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R6", "gates in reset", int'({l1h, l1l, l2h, l2l}), 0);
        end
        rst_n = 1'b1;
        for (int k = 1; k <= DT + 2; k++) begin
            @(negedge clk);
            if (k == 1) check("R1", "first trigger after release", int'(trig), 1);
            if (k <= DT + 1)
                check("R6", $sformatf("gates quiet at clock %0d", k), int'({l1h, l1l, l2h, l2l}), 0);
            else
                check("R6", "lower gates rise at clock DT+2", int'({l1h, l1l, l2h, l2l}), 5);
        end

        // R1: trigger spacing and width
        last = -1; cyc = 0; seen_cnt = 0; wide = 0;
        for (int i = 0; i < 10 * PER; i++) begin
            @(negedge clk);
            cyc++;
            if (trig) begin
                if (last >= 0) begin
                    check("R1", "trigger spacing", cyc - last, PER);
                    if (cyc - last == 1) wide++;
                end
                last = cyc;
                seen_cnt++;
            end
        end
        check("R1", "trigger count in ten periods", seen_cnt, 10);
        check("R1", "trigger width over one clock", wide, 0);

        // R2 R3 R4 R7: sweep every compare value, both signs
        for (int c = -16; c <= 15; c++) run_cmd(c * 2048);
        run_cmd(32767);
        check("R7", "scale of +32767", scale(32767), PRD - 1);
        run_cmd(1000);
        run_cmd(-1000);
        run_cmd(30000);
        run_cmd(-3100);

        // R5: mid-period change waits for the valley
        run_cmd(4 * 2048);
        while (!trig) @(negedge clk);
        for (int i = 0; i < PER; i++) begin
            pat[i] = l1h;
            @(negedge clk);
        end
        check("R1", "trigger at period boundary", int'(trig), 1);
        for (int i = 0; i < PRD; i++) @(negedge clk);
        cmd = 16'(12 * 2048);
        for (int o = PRD; o <= PER + 1; o++) begin
            check("R5", $sformatf("leg1 upper held at offset %0d", o), int'(l1h), int'(pat[o % PER]));
            @(negedge clk);
        end
        run_cmd(12 * 2048);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule